// File: doc/BRIEF.md
# Flash Command Interpreter

This block decodes the command cycles that software writes to a NOR flash device that answers common flash interface queries. Every bus write carries a command byte in its low 8 bits. Some commands finish in one cycle. These select what reads return, or clear the status. Other commands open a sequence of two or more cycles: block erase, block lock or unlock, single-word program, and buffered program. Separate registers hold the write-sequence state and the read mode, so a sequence can change what reads return while it is still in progress.

Reads take one of four sources. The first is array data, passed through from the flash array. The second is the status byte. The third is an identifier word, which gives the vendor code, the device code, or the lock bit of the addressed block. The fourth is an entry of the parameter query table. Two 16-bit chips share a 32-bit bus, so every value that does not come from the array is copied into both halves. The block holds the per-block lock bits itself. It also tracks how full the program buffer is. It signals the erase engine, the word programmer and the program buffer with single-cycle pulses. Those pulses share an address bus and a data bus. The array timing and the voltage behaviour are outside this block.

Top module: `cfi_cmd_fsm`

## Requirements
- R1: After reset the read mode is array, the write sequence is idle, the status is 0x80 and every block is unlocked.
- R2: The command byte is wdata[7:0]. In idle, 0xFF selects array reads, 0x90 selects identifier reads, 0x98 selects query reads and 0x70 selects status reads.
- R3: A read request returns rd_valid_o with data one cycle later. In array mode the data is array_rdata_i, unchanged.
- R4: Status bit 7 means ready and is always 1. Bit 5 means erase or sequence error, bit 4 means program error and bit 1 means locked block. These bits are sticky. 0x50 restores 0x80. In idle, 0xF0 and unknown codes change nothing.
- R5: 0x20 followed by 0xD0 pulses erase_o, with op_addr_o set to the block base, one cycle after the confirm. If the block is locked, no pulse is issued and status becomes 0xA2. Any other second code sets 0xB0. Afterwards reads return status.
- R6: 0x60 followed by 0x01 locks the addressed block. 0x60 followed by 0xD0 unlocks it. Any other second code sets 0xB0.
- R7: 0x40 or 0x10, then a data write, pulses prog_o with that address and data. If the block is locked, no pulse is issued and status becomes 0x92.
- R8: 0xE8, then a length write with wdata[15:0]=n, pulses pbuf_init_o with op_data_o=min(n+1, BUF_WORDS) words. Each following write pulses pbuf_wr_o until that count is reached. A write outside the BUF_WORDS*4 byte window from the first data address also ends the data phase.
- R9: The cycle after the data phase must carry 0xD0. That pulses pbuf_commit_o with op_addr_o set to the first data address. If that block is locked, status becomes 0x92. If the code is not 0xD0, status becomes 0xB0.
- R10: For identifier reads, the index is addr[7:0]/BANK_W. Index 0 gives VENDOR_ID, 1 gives DEVICE_ID, 2 gives the lock bit of the addressed block, and every other index gives 0.
- R11: For query reads, the index is addr/BANK_W. Entries 0x10–0x12 are "QRY", 0x27 is log2 of the device size, 0x2A is log2 of the buffer bytes, 0x2D–0x2E give the block count and 0x2F–0x30 give the block bytes. Unused entries, and entries at index 61 or above, read 0.
- R12: With DUAL_CHIP set, every non-array read carries its 16-bit value in both halves. At most one operation pulse is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset into the device |
| req_wdata_i | input | 32 | Write data; command byte in bits 7:0 |
| array_rdata_i | input | 32 | Array data for req_addr_i |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| prog_o | output | 1 | Word program pulse |
| erase_o | output | 1 | Block erase pulse (engine fills the block with 0xFF) |
| pbuf_init_o | output | 1 | Program buffer setup pulse; op_data_o = word count |
| pbuf_wr_o | output | 1 | Program buffer data pulse |
| pbuf_commit_o | output | 1 | Program buffer write-back pulse |
| op_addr_o | output | ADDR_W | Address for the current pulse |
| op_data_o | output | 32 | Data for the current pulse |

## Verification
A corrupted write-sequence state causes errors at the ports. The next data write is then taken as a command, or a command is taken as data. The result is a missing or extra pulse in the cycle after that write, or a status read that shows 0xB0. A wrong read mode or lock bit shows up on the first read after the fault. Every sequence is therefore followed at once by a status or identifier read. The lock bits of all blocks are swept through the identifier view.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
  typedef enum logic [2:0] {W_IDLE, W_ERASE, W_LOCK, W_PROG, W_BLEN, W_BDATA} wstate_t;
  typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_ID, M_QUERY} rmode_t;

  localparam logic [7:0] C_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] C_RD_ID     = 8'h90;
  localparam logic [7:0] C_QUERY     = 8'h98;
  localparam logic [7:0] C_RD_STATUS = 8'h70;
  localparam logic [7:0] C_CLR_STAT  = 8'h50;
  localparam logic [7:0] C_ERASE     = 8'h20;
  localparam logic [7:0] C_LOCK_SET  = 8'h60;
  localparam logic [7:0] C_LOCK      = 8'h01;
  localparam logic [7:0] C_PROG      = 8'h40;
  localparam logic [7:0] C_PROG_ALT  = 8'h10;
  localparam logic [7:0] C_BUF       = 8'hE8;
  localparam logic [7:0] C_CONFIRM   = 8'hD0;

  localparam logic [7:0] ST_READY  = 8'h80;
  localparam logic [7:0] ST_ERASE  = 8'h20;
  localparam logic [7:0] ST_PROG   = 8'h10;
  localparam logic [7:0] ST_LOCKED = 8'h02;

  function automatic logic [7:0] query_byte(input int idx, input int size_log2,
                                            input int nblk, input int blk_bytes,
                                            input int buf_log2);
    case (idx)
      16: return 8'h51;
      17: return 8'h52;
      18: return 8'h59;
      19: return 8'h01;
      21: return 8'h31;
      27: return 8'h45;
      28: return 8'h55;
      31, 32, 33: return 8'h01;
      39: return size_log2[7:0];
      40: return 8'h05;
      42: return buf_log2[7:0];
      43: return buf_log2[15:8];
      44: return 8'h01;
      45: return nblk[7:0];
      46: return nblk[15:8];
      47: return blk_bytes[7:0];
      48: return blk_bytes[15:8];
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfi_lock_table.sv
module cfi_lock_table #(
  parameter int NBLK = 4,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [BW-1:0] wr_blk_i,
  input  logic [BW-1:0] blk_a_i,
  input  logic [BW-1:0] blk_b_i,
  output logic          lock_a_o,
  output logic          lock_b_o,
  output logic [NBLK-1:0] bits_o
);
  logic [NBLK-1:0] lk_q;

  for (genvar i = 0; i < NBLK; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lk_q[i] <= 1'b0;
      else if (set_i && wr_blk_i == BW'(i)) lk_q[i] <= 1'b1;
      else if (clr_i && wr_blk_i == BW'(i)) lk_q[i] <= 1'b0;
    end
  end

  assign lock_a_o = lk_q[blk_a_i];
  assign lock_b_o = lk_q[blk_b_i];
  assign bits_o   = lk_q;
endmodule

// File: rtl/cfi_buf_tracker.sv
module cfi_buf_tracker #(
  parameter int ADDR_W    = 12,
  parameter int BUF_WORDS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [15:0]       len_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              full_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [15:0]       len_words_o
);
  localparam int CW = $clog2(BUF_WORDS + 1);

  logic [CW-1:0]     cnt_q, len_q;
  logic [ADDR_W-1:0] base_q, offs;
  logic              in_win;

  assign len_words_o = (len_i >= 16'(BUF_WORDS - 1)) ? 16'(BUF_WORDS) : len_i + 16'd1;
  assign offs   = addr_i - base_q;
  assign in_win = (addr_i >= base_q) && (offs < ADDR_W'(BUF_WORDS * 4));
  assign full_o = (cnt_q >= len_q) || (cnt_q != '0 && !in_win);
  assign base_o = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      len_q  <= '0;
      base_q <= '0;
    end else if (init_i) begin
      cnt_q <= '0;
      len_q <= CW'(len_words_o);
    end else if (wr_i && !full_o) begin
      if (cnt_q == '0) base_q <= addr_i;
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/cfi_read_mux.sv
module cfi_read_mux #(
  parameter int ADDR_W = 12,
  parameter int BLK_W  = 10,
  parameter int BUF_WORDS = 8,
  parameter int BANK_W = 4,
  parameter logic [15:0] VENDOR_ID = 16'h0089,
  parameter logic [15:0] DEVICE_ID = 16'h0018,
  parameter bit  DUAL_CHIP = 1'b1
) (
  input  cfi_pkg::rmode_t   mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        status_i,
  input  logic              lock_i,
  input  logic [31:0]       array_i,
  output logic [31:0]       data_o
);
  import cfi_pkg::*;
  localparam int SH       = $clog2(BANK_W);
  localparam int NBLK     = 1 << (ADDR_W - BLK_W);
  localparam int BUF_LOG2 = $clog2(BUF_WORDS * 4);

  logic [7:0]        id_idx;
  logic [ADDR_W-1:0] q_idx;
  logic [15:0]       v16;

  assign id_idx = addr_i[7:0] >> SH;
  assign q_idx  = addr_i >> SH;

  always_comb begin
    case (mode_i)
      M_STATUS: v16 = {8'h00, status_i};
      M_ID: case (id_idx)
        8'd0:    v16 = VENDOR_ID;
        8'd1:    v16 = DEVICE_ID;
        8'd2:    v16 = {15'd0, lock_i};
        default: v16 = 16'h0;
      endcase
      M_QUERY: v16 = {8'h00, query_byte(int'(q_idx), ADDR_W, NBLK, 1 << BLK_W, BUF_LOG2)};
      default: v16 = 16'h0;
    endcase
    if (mode_i == M_ARRAY) data_o = array_i;
    else if (DUAL_CHIP)    data_o = {v16, v16};
    else                   data_o = {16'h0, v16};
  end
endmodule

// File: rtl/cfi_cmd_fsm.sv
module cfi_cmd_fsm #(
  parameter int ADDR_W    = 12,
  parameter int BLK_W     = 10,
  parameter int BUF_WORDS = 8,
  parameter int BANK_W    = 4,
  parameter logic [15:0] VENDOR_ID = 16'h0089,
  parameter logic [15:0] DEVICE_ID = 16'h0018,
  parameter bit  DUAL_CHIP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [31:0]       array_rdata_i,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o,
  output logic              prog_o,
  output logic              erase_o,
  output logic              pbuf_init_o,
  output logic              pbuf_wr_o,
  output logic              pbuf_commit_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [31:0]       op_data_o
);
  import cfi_pkg::*;
  localparam int BW   = ADDR_W - BLK_W;
  localparam int NBLK = 1 << BW;

  wstate_t ws_q, ws_d;
  rmode_t  rm_q, rm_d;
  logic [7:0] st_q, st_d;
  logic [NBLK-1:0] lock_bits;
  logic wr, lk_set, lk_clr, lock_a, lock_b, buf_full;
  logic prog_d, erase_d, binit_d, bwr_d, bcommit_d;
  logic [ADDR_W-1:0] op_addr_d, buf_base;
  logic [31:0] op_data_d, rd_mux;
  logic [15:0] len_words;
  logic [7:0]  cmd;
  logic [BW-1:0] blk;

  assign wr  = req_valid_i && req_write_i;
  assign cmd = req_wdata_i[7:0];
  assign blk = req_addr_i[ADDR_W-1:BLK_W];

  cfi_lock_table #(.NBLK(NBLK)) u_locks (
    .clk_i, .rst_ni, .set_i(lk_set), .clr_i(lk_clr), .wr_blk_i(blk),
    .blk_a_i(blk), .blk_b_i(buf_base[ADDR_W-1:BLK_W]),
    .lock_a_o(lock_a), .lock_b_o(lock_b), .bits_o(lock_bits));

  cfi_buf_tracker #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) u_buf (
    .clk_i, .rst_ni, .init_i(wr && ws_q == W_BLEN), .len_i(req_wdata_i[15:0]),
    .wr_i(wr && ws_q == W_BDATA), .addr_i(req_addr_i), .full_o(buf_full),
    .base_o(buf_base), .len_words_o(len_words));

  cfi_read_mux #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUF_WORDS(BUF_WORDS), .BANK_W(BANK_W),
                 .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .DUAL_CHIP(DUAL_CHIP)) u_rmux (
    .mode_i(rm_q), .addr_i(req_addr_i), .status_i(st_q), .lock_i(lock_a),
    .array_i(array_rdata_i), .data_o(rd_mux));

  always_comb begin
    ws_d = ws_q; rm_d = rm_q; st_d = st_q;
    lk_set = 1'b0; lk_clr = 1'b0;
    prog_d = 1'b0; erase_d = 1'b0; binit_d = 1'b0; bwr_d = 1'b0; bcommit_d = 1'b0;
    op_addr_d = op_addr_o; op_data_d = op_data_o;
    if (wr) begin
      case (ws_q)
        W_IDLE: case (cmd)
          C_RD_ARRAY:  rm_d = M_ARRAY;
          C_RD_ID:     rm_d = M_ID;
          C_QUERY:     rm_d = M_QUERY;
          C_RD_STATUS: rm_d = M_STATUS;
          C_CLR_STAT:  st_d = ST_READY;
          C_ERASE:     begin ws_d = W_ERASE; rm_d = M_STATUS; end
          C_LOCK_SET:  ws_d = W_LOCK;
          C_PROG, C_PROG_ALT: begin ws_d = W_PROG; rm_d = M_STATUS; end
          C_BUF:       begin ws_d = W_BLEN; rm_d = M_STATUS; end
          default: ;  // vendor reset and unknown codes are ignored
        endcase
        W_ERASE: begin
          ws_d = W_IDLE; rm_d = M_STATUS;
          if (cmd != C_CONFIRM) st_d = st_q | ST_ERASE | ST_PROG;
          else if (lock_a)      st_d = st_q | ST_ERASE | ST_LOCKED;
          else begin
            erase_d = 1'b1;
            op_addr_d = {blk, {BLK_W{1'b0}}};
          end
        end
        W_LOCK: begin
          ws_d = W_IDLE; rm_d = M_STATUS;
          if (cmd == C_LOCK)         lk_set = 1'b1;
          else if (cmd == C_CONFIRM) lk_clr = 1'b1;
          else                       st_d = st_q | ST_ERASE | ST_PROG;
        end
        W_PROG: begin
          ws_d = W_IDLE; rm_d = M_STATUS;
          if (lock_a) st_d = st_q | ST_PROG | ST_LOCKED;
          else begin
            prog_d = 1'b1; op_addr_d = req_addr_i; op_data_d = req_wdata_i;
          end
        end
        W_BLEN: begin
          ws_d = W_BDATA; binit_d = 1'b1;
          op_addr_d = req_addr_i; op_data_d = {16'h0, len_words};
        end
        W_BDATA: begin
          if (!buf_full) begin
            bwr_d = 1'b1; op_addr_d = req_addr_i; op_data_d = req_wdata_i;
          end else begin
            ws_d = W_IDLE;
            if (cmd != C_CONFIRM) st_d = st_q | ST_ERASE | ST_PROG;
            else if (lock_b)      st_d = st_q | ST_PROG | ST_LOCKED;
            else begin
              bcommit_d = 1'b1; op_addr_d = buf_base;
            end
          end
        end
        default: ws_d = W_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q <= W_IDLE; rm_q <= M_ARRAY; st_q <= ST_READY;
      prog_o <= 1'b0; erase_o <= 1'b0; pbuf_init_o <= 1'b0;
      pbuf_wr_o <= 1'b0; pbuf_commit_o <= 1'b0;
      op_addr_o <= '0; op_data_o <= '0;
      rd_valid_o <= 1'b0; rd_data_o <= '0;
    end else begin
      ws_q <= ws_d; rm_q <= rm_d; st_q <= st_d;
      prog_o <= prog_d; erase_o <= erase_d; pbuf_init_o <= binit_d;
      pbuf_wr_o <= bwr_d; pbuf_commit_o <= bcommit_d;
      op_addr_o <= op_addr_d; op_data_o <= op_data_d;
      rd_valid_o <= req_valid_i && !req_write_i;
      if (req_valid_i && !req_write_i) rd_data_o <= rd_mux;
    end
  end
endmodule

// File: rtl/cfi_cmd_fsm_chk.sv
module cfi_cmd_fsm_chk #(
  parameter int ADDR_W = 12,
  parameter int BLK_W  = 10,
  parameter bit DUAL_CHIP = 1'b1,
  localparam int NBLK = 1 << (ADDR_W - BLK_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic              rd_valid_o,
  input logic [31:0]       rd_data_o,
  input logic              prog_o,
  input logic              erase_o,
  input logic              pbuf_init_o,
  input logic              pbuf_wr_o,
  input logic              pbuf_commit_o,
  input logic [ADDR_W-1:0] op_addr_o,
  input cfi_pkg::wstate_t  ws_q,
  input cfi_pkg::rmode_t   rm_q,
  input logic [NBLK-1:0]   lock_bits
);
  import cfi_pkg::*;

  a_r12_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_o, erase_o, pbuf_init_o, pbuf_wr_o, pbuf_commit_o}));

  a_r3_rd_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(req_valid_i && !req_write_i));

  a_r12_dual_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DUAL_CHIP && rd_valid_o && $past(rm_q) != M_ARRAY) |-> rd_data_o[31:16] == rd_data_o[15:0]);

  a_r5_erase_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> (!lock_bits[op_addr_o[ADDR_W-1:BLK_W]] && ws_q == W_IDLE));

  a_r7_prog_ends_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> ws_q == W_IDLE);

  a_r8_buf_in_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pbuf_init_o || pbuf_wr_o) |-> ws_q == W_BDATA);

  a_r9_commit_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pbuf_commit_o |-> (ws_q == W_IDLE && !lock_bits[op_addr_o[ADDR_W-1:BLK_W]]));
endmodule

bind cfi_cmd_fsm cfi_cmd_fsm_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DUAL_CHIP(DUAL_CHIP)) u_chk (.*);

// File: tb/tb_cfi_cmd_fsm.sv
module tb_cfi_cmd_fsm;
  localparam int AW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0, array_rdata, rd_data, op_data;
  logic rd_valid, prog, erase, binit, bwr, bcommit;
  logic [AW-1:0] op_addr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [4:0] cap;  // {prog, erase, init, wr, commit}
  logic [AW-1:0] cap_addr;
  logic [31:0] cap_data, rv;

  always #5 clk = ~clk;
  assign array_rdata = {4'hA, req_addr, 4'h5, req_addr};

  cfi_cmd_fsm dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .array_rdata_i(array_rdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .prog_o(prog), .erase_o(erase),
    .pbuf_init_o(binit), .pbuf_wr_o(bwr), .pbuf_commit_o(bcommit),
    .op_addr_o(op_addr), .op_data_o(op_data));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    cap = {prog, erase, binit, bwr, bcommit}; cap_addr = op_addr; cap_data = op_data;
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); #1;
    v = rd_valid ? rd_data : 32'hDEAD_BEEF;
    req_valid = 0;
  endtask

  function automatic logic [31:0] dup(input logic [15:0] v);
    return {v, v};
  endfunction

  task automatic chk_status(input logic [7:0] s, input string tag);
    rd(12'h0, rv);
    chk(rv == dup({8'h0, s}), tag, rv, dup({8'h0, s}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state, array mode
    chk({prog, erase, binit, bwr, bcommit} == 5'b0, "R1 pulses idle", {27'b0, prog, erase, binit, bwr, bcommit}, 0);
    for (int a = 0; a < 4096; a += 1020) begin
      rd(AW'(a), rv);
      chk(rv == {4'hA, AW'(a), 4'h5, AW'(a)}, "R1 R3 array read", rv, {4'hA, AW'(a), 4'h5, AW'(a)});
    end
    wr(0, 32'h70); chk_status(8'h80, "R1 R2 R4 status after reset");
    // R10 identifier sweep
    wr(0, 32'h90);
    for (int i = 0; i < 6; i++) begin
      logic [15:0] e;
      e = (i == 0) ? 16'h0089 : (i == 1) ? 16'h0018 : 16'h0;
      rd(AW'(i * 4), rv);
      chk(rv == dup(e), "R10 R12 identifier", rv, dup(e));
    end
    // R11 query table
    wr(0, 32'h98);
    for (int i = 0; i < 16; i++) begin
      rd(AW'(i * 4), rv);
      chk(rv == 0, "R11 query lead zeros", rv, 0);
    end
    rd(12'h40, rv); chk(rv == dup(16'h51), "R11 Q", rv, dup(16'h51));
    rd(12'h44, rv); chk(rv == dup(16'h52), "R11 R", rv, dup(16'h52));
    rd(12'h48, rv); chk(rv == dup(16'h59), "R11 Y", rv, dup(16'h59));
    rd(12'h9C, rv); chk(rv == dup(16'd12), "R11 size log2", rv, dup(16'd12));
    rd(12'hA8, rv); chk(rv == dup(16'd5), "R11 buffer log2", rv, dup(16'd5));
    rd(12'hB4, rv); chk(rv == dup(16'd4), "R11 block count lo", rv, dup(16'd4));
    rd(12'hB8, rv); chk(rv == 0, "R11 block count hi", rv, 0);
    rd(12'hC0, rv); chk(rv == dup(16'd4), "R11 block bytes hi", rv, dup(16'd4));
    rd(12'hF4, rv); chk(rv == 0, "R11 index 61", rv, 0);
    wr(0, 32'hFF); rd(12'h123, rv);
    chk(rv == {4'hA, 12'h123, 4'h5, 12'h123}, "R2 R3 back to array", rv, {4'hA, 12'h123, 4'h5, 12'h123});
    // R5 erase every block
    for (int b = 0; b < 4; b++) begin
      wr(AW'(b * 1024 + 20), 32'h20); wr(AW'(b * 1024 + 20), 32'hD0);
      chk(cap == 5'b01000 && cap_addr == AW'(b * 1024), "R5 erase pulse", {cap, 15'b0, cap_addr}, {5'b01000, 15'b0, AW'(b * 1024)});
      chk_status(8'h80, "R5 status after erase");
    end
    // R6 lock block 2, sweep lock bits
    wr(12'h800, 32'h60); wr(12'h800, 32'h01);
    wr(0, 32'h90);
    for (int b = 0; b < 4; b++) begin
      rd(AW'(b * 1024 + 8), rv);
      chk(rv == dup({15'b0, b == 2}), "R6 R10 lock bit", rv, dup({15'b0, b == 2}));
    end
    wr(12'h810, 32'h20); wr(12'h810, 32'hD0);
    chk(cap == 0, "R5 locked no erase", {27'b0, cap}, 0);
    chk_status(8'hA2, "R5 locked erase status");
    wr(0, 32'h50); chk_status(8'h80, "R4 clear status");
    wr(0, 32'h20); wr(0, 32'hFF); chk_status(8'hB0, "R5 bad confirm");
    wr(0, 32'h50); wr(0, 32'h60); wr(0, 32'h33); chk_status(8'hB0, "R6 bad lock code");
    wr(0, 32'h50); wr(12'h800, 32'h60); wr(12'h800, 32'hD0);
    wr(0, 32'h90); rd(12'h808, rv); chk(rv == 0, "R6 unlock", rv, 0);
    // R4 ignored codes
    wr(0, 32'h70); wr(0, 32'hF0); wr(0, 32'h33);
    chk(cap == 0, "R4 ignored no pulse", {27'b0, cap}, 0);
    chk_status(8'h80, "R4 ignored keeps mode and status");
    // R7 word program
    wr(0, 32'h40); wr(12'h010, 32'h1234_5678);
    chk(cap == 5'b10000 && cap_addr == 12'h010 && cap_data == 32'h1234_5678, "R7 program", cap_data, 32'h1234_5678);
    wr(0, 32'h10); wr(12'h404, 32'hCAFE_0001);
    chk(cap == 5'b10000 && cap_addr == 12'h404 && cap_data == 32'hCAFE_0001, "R7 alt program", cap_data, 32'hCAFE_0001);
    wr(12'hC00, 32'h60); wr(12'hC00, 32'h01);
    wr(0, 32'h40); wr(12'hC04, 32'h5555_AAAA);
    chk(cap == 0, "R7 locked no program", {27'b0, cap}, 0);
    chk_status(8'h92, "R7 locked program status");
    wr(0, 32'h50);
    // R8 R9 buffered program, length 3 words
    wr(12'h100, 32'hE8); wr(12'h100, 32'h2);
    chk(cap == 5'b00100 && cap_data == 3, "R8 init length", cap_data, 3);
    for (int k = 0; k < 3; k++) begin
      wr(AW'(12'h100 + k * 4), 32'h1000 + k);
      chk(cap == 5'b00010 && cap_addr == AW'(12'h100 + k * 4), "R8 data write", {cap, 15'b0, cap_addr}, {5'b00010, 15'b0, AW'(12'h100 + k * 4)});
    end
    wr(12'h100, 32'hD0);
    chk(cap == 5'b00001 && cap_addr == 12'h100, "R9 commit", {cap, 15'b0, cap_addr}, {5'b00001, 15'b0, 12'h100});
    chk_status(8'h80, "R9 status clean");
    // R8 cap and window end
    wr(12'h200, 32'hE8); wr(12'h200, 32'd100);
    chk(cap_data == 8, "R8 length cap", cap_data, 8);
    wr(12'h200, 32'h1); wr(12'h240, 32'hD0);
    chk(cap == 5'b00001 && cap_addr == 12'h200, "R8 R9 window end commit", {cap, 15'b0, cap_addr}, {5'b00001, 15'b0, 12'h200});
    // R9 wrong final code, locked target
    wr(12'h300, 32'hE8); wr(12'h300, 32'h0); wr(12'h300, 32'h7); wr(12'h300, 32'hFF);
    chk(cap == 0, "R9 bad final no commit", {27'b0, cap}, 0);
    chk_status(8'hB0, "R9 bad final status");
    wr(0, 32'h50);
    wr(12'hC00, 32'hE8); wr(12'hC00, 32'h0); wr(12'hC00, 32'h9);
    chk(cap == 5'b00010, "R8 data to locked block", {27'b0, cap}, 2);
    wr(12'hC00, 32'hD0);
    chk(cap == 0, "R9 locked no commit", {27'b0, cap}, 0);
    chk_status(8'h92, "R9 locked commit status");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule